// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog peripheral on a simple register bus with single-cycle reads and writes. A prescaler divides the clock by a fixed factor (4 by default), and each prescaled tick takes one count off a down-counter (24 bits by default). Software reloads the counter only by writing a two-byte key to the feed register: 0xAA first, then 0x55. If the counter is allowed to run out, the block sets a sticky timeout flag. When reset mode is armed, it also pulses a system reset output.

Setting the enable bit does not start the count. Counting begins with the first valid feed that follows. After that, no register write can stop it. A broken key sequence is treated as a fault: a first key byte followed by any other byte on the feed register, while the watchdog is enabled with reset mode, forces a reset at once. An access to any other register between the two key bytes silently cancels the feed.

Top module: `wdog_keyed`

## Requirements
- R1: While running, the counter loses one count per PRESCALE clocks. A read of the count register taken n clocks after the clock edge that completed a valid feed returns TC - floor(n/PRESCALE), where TC is the stored reload value.
- R2: Register byte offsets: 0x0 control, 0x4 reload, 0x8 feed (reads as 0), 0xC live count. Control bits: bit 0 enable, bit 1 reset mode, bit 2 timeout flag (read-only). After reset, control reads 0, and both reload and count read MIN_RELOAD.
- R3: A reload write keeps only the low CNT_W bits of the data. A value below MIN_RELOAD is stored as MIN_RELOAD.
- R4: A feed write whose low byte is 0xAA, followed by a feed write whose low byte is 0x55, loads the counter from the reload register. Upper data bits are ignored.
- R5: A read or write of any other register between the two key bytes cancels the feed. The later 0x55 then leaves the counter untouched and raises no reset.
- R6: Until a valid feed occurs with the enable bit set, the count holds its value. A valid feed before enable only loads the counter.
- R7: The enable and reset-mode bits can only be set. Writing zeros to them changes nothing, and a running count keeps running.
- R8: After 0xAA, a feed write of any byte other than 0x55 loads nothing. If enable and reset mode are both set, sys_reset is high for the following clock. Otherwise sys_reset stays low.
- R9: A tick that finds the count at zero sets the sticky timeout flag and reloads the counter. If reset mode is set, it also drives sys_reset high for exactly that one following clock, which is PRESCALE*(TC+1) clocks after the feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| timeout_flag | output | 1 | Sticky expiry flag, same as control bit 2 |
| sys_reset | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with CNT_W=10 and MIN_RELOAD=8, and keeps the default PRESCALE of 4. With these values a full expiry takes fewer than a hundred clocks. That lets the bench sweep every reload value from 0 to 20 through the clamp and check the count on every clock of a countdown. It also runs each reload value from 8 to 16 through to expiry, checking the exact cycle of the reset pulse. Aborted, broken and valid key sequences are each driven with and without reset mode armed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_RELOAD = 'h4;
  localparam int unsigned OFS_FEED   = 'h8;
  localparam int unsigned OFS_COUNT  = 'hC;

  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_RST  = 1;
  localparam int unsigned CTRL_FLAG = 2;

  // Masks a raw write to w bits and raises it to the floor lo.
  function automatic logic [31:0] clamp_reload(input logic [31:0] raw,
                                               input int unsigned w,
                                               input logic [31:0] lo);
    logic [31:0] v;
    v = (w >= 32) ? raw : (raw & ((32'd1 << w) - 32'd1));
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (clear)          phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  if (DIV > 1) begin : g_chk
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("prescaled ticks on adjacent clocks");
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned W       = 24,
  parameter int unsigned RST_VAL = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= W'(RST_VAL);
    else if (load || expire)   count <= load_val;
    else if (tick)             count <= count - 1'b1;
  end

  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count))
    else $error("count moved without a tick");

  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count != '0) |=> (count == $past(count) - W'(1)))
    else $error("count did not step down by one");

  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)))
    else $error("load did not take the reload value");
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_access,
  input  logic       feed_wr,
  input  logic [7:0] key,
  output logic       feed_ok,
  output logic       feed_bad
);
  logic armed;

  assign feed_ok  = armed && feed_wr && (key == KEY_FIRE);
  assign feed_bad = armed && feed_wr && (key != KEY_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   armed <= 1'b0;
    else if (!armed && feed_wr && key == KEY_ARM) armed <= 1'b1;
    else if (any_access)                          armed <= 1'b0;
  end

  assert_access_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && any_access) |=> !armed)
    else $error("key state survived an access");

  assert_arm_needs_feed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(feed_wr))
    else $error("armed without a feed write");
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned MIN_RELOAD = 255,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timeout_flag,
  output logic              sys_reset
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             mode_en, mode_rst, flag_q, running;
  logic             tick, expire, feed_ok, feed_bad;
  logic             sel_ctrl, sel_reload, sel_feed, sel_count;
  logic             unused_wdata;

  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign sel_feed   = (bus_addr == ADDR_W'(OFS_FEED));
  assign sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign unused_wdata = ^bus_wdata;

  function automatic logic [CNT_W-1:0] reload_of(input logic [DATA_W-1:0] raw);
    return CNT_W'(clamp_reload(32'(raw), CNT_W, 32'(FLOOR)));
  endfunction

  wdog_feed_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .any_access(bus_wr || bus_rd),
    .feed_wr(bus_wr && sel_feed),
    .key(bus_wdata[7:0]),
    .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  wdog_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(feed_ok), .run(running), .tick(tick)
  );

  wdog_counter #(.W(CNT_W), .RST_VAL(MIN_RELOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .load_val(reload_q),
    .tick(tick), .count(count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= FLOOR;
      mode_en   <= 1'b0;
      mode_rst  <= 1'b0;
      flag_q    <= 1'b0;
      running   <= 1'b0;
      sys_reset <= 1'b0;
    end else begin
      if (bus_wr && sel_reload) reload_q <= reload_of(bus_wdata);
      if (bus_wr && sel_ctrl) begin
        mode_en  <= mode_en  | bus_wdata[CTRL_EN];
        mode_rst <= mode_rst | bus_wdata[CTRL_RST];
      end
      running   <= running | (feed_ok & mode_en);
      flag_q    <= flag_q | expire;
      sys_reset <= mode_rst & (expire | (feed_bad & mode_en));
    end
  end

  assign timeout_flag = flag_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CTRL_EN]   = mode_en;
      bus_rdata[CTRL_RST]  = mode_rst;
      bus_rdata[CTRL_FLAG] = flag_q;
    end else if (sel_reload) begin
      bus_rdata[CNT_W-1:0] = reload_q;
    end else if (sel_count) begin
      bus_rdata[CNT_W-1:0] = count;
    end
  end

  assert_cannot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running)
    else $error("running watchdog stopped");

  assert_start_by_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(feed_ok) && $past(mode_en)))
    else $error("count started without an enabled feed");

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag)
    else $error("timeout flag cleared");

  assert_reset_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> $past(mode_rst))
    else $error("reset pulse without reset mode");

  assert_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_reload) |=> (reload_q >= FLOOR))
    else $error("reload below floor");
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 10;
  localparam int MIN = 8;
  localparam int PS  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timeout_flag, sys_reset;

  int errors = 0, checks = 0, n = 0;
  bit done = 1'b0;

  wdog_keyed #(.CNT_W(CW), .PRESCALE(PS), .MIN_RELOAD(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timeout_flag(timeout_flag), .sys_reset(sys_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    n += k;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    n++;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    n++;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
    n = 0;
  endtask

  function automatic int clampv(input int v);
    int m;
    m = v & ((1 << CW) - 1);
    return (m < MIN) ? MIN : m;
  endfunction

  task automatic chk_count(input string req, input int tc);
    logic [31:0] v;
    int at;
    at = n;
    rd(4'hC, v);
    check(req, v, 32'(tc - at / PS));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(4'h0, v); check("R2 ctrl reset", v, 0);
    rd(4'h4, v); check("R2 reload reset", v, MIN);
    rd(4'hC, v); check("R2 count reset", v, MIN);
    rd(4'h8, v); check("R2 feed reads zero", v, 0);
    check("R2 flag reset", timeout_flag, 0);
    check("R2 sys_reset reset", sys_reset, 0);

    // R3 clamp sweep
    for (int i = 0; i <= 20; i++) begin
      wr(4'h4, 32'(i));
      rd(4'h4, v); check("R3 clamp", v, 32'(clampv(i)));
    end
    wr(4'h4, 32'h0000_F00C);
    rd(4'h4, v); check("R3 upper bits dropped", v, 32'(clampv(32'h0000_F00C)));

    // R6 feed before enable only loads
    wr(4'h4, 32'd20);
    feed();
    chk_count("R6 feed loads while disabled", 20 + n / PS);
    idle(20);
    rd(4'hC, v); check("R6 count holds while disabled", v, 20);
    wr(4'h0, 32'h1);
    idle(12);
    rd(4'hC, v); check("R6 enable alone holds count", v, 20);
    rd(4'h0, v); check("R2 enable bit", v, 1);

    // R1/R4 countdown after valid feed
    feed();
    for (int i = 0; i <= 40; i++) chk_count("R1 countdown", 20);

    // R7 cannot disable
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R7 enable stays set", v, 1);
    chk_count("R7 keeps counting", 20);

    // R5 aborted sequences
    wr(4'h8, 32'hAA);
    rd(4'h4, v);
    wr(4'h8, 32'h55);
    chk_count("R5 read aborts feed", 20);
    wr(4'h8, 32'hAA);
    wr(4'h4, 32'd20);
    wr(4'h8, 32'h55);
    chk_count("R5 write aborts feed", 20);
    check("R5 no reset on abort", sys_reset, 0);

    // R8 broken key without reset mode
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h12);
    check("R8 no pulse without reset mode", sys_reset, 0);
    chk_count("R8 broken key loads nothing", 20);

    // R9 expiry without reset mode
    idle(PS * 21 - 1 - n);
    check("R9 flag before expiry", timeout_flag, 0);
    idle(1);
    check("R9 flag at expiry", timeout_flag, 1);
    check("R9 no pulse without reset mode", sys_reset, 0);
    rd(4'hC, v); check("R9 reload on expiry", v, 20);

    // R7/R2 reset mode set, flag kept
    wr(4'h0, 32'h2);
    rd(4'h0, v); check("R2 ctrl all bits", v, 7);

    // R4 upper data bits ignored on keys, then expiry with pulse
    wr(4'h8, 32'hABCD_00AA);
    wr(4'h8, 32'h0000_7755);
    n = 0;
    chk_count("R4 key upper bits ignored", 20);
    idle(PS * 21 - 1 - n);
    check("R9 no pulse before expiry", sys_reset, 0);
    idle(1);
    check("R9 pulse at expiry", sys_reset, 1);
    idle(1);
    check("R9 pulse one clock", sys_reset, 0);

    // R8 broken key with reset mode
    feed();
    idle(20);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h33);
    check("R8 pulse on broken key", sys_reset, 1);
    idle(1);
    check("R8 pulse ends", sys_reset, 0);
    chk_count("R8 no reload on broken key", 20);

    // R1/R9 sweep of reload values to expiry
    for (int tc = MIN; tc <= 16; tc++) begin
      wr(4'h4, 32'(tc));
      feed();
      chk_count("R1 sweep start", tc);
      idle(PS * (tc + 1) - 1 - n);
      check("R9 sweep before expiry", sys_reset, 0);
      idle(1);
      check("R9 sweep pulse", sys_reset, 1);
      rd(4'hC, v); check("R9 sweep reload", v, 32'(tc));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule